// File: doc/BRIEF.md
# Tick-Counting Real-Time Clock Core with Alarm

This core keeps time for a power-management device as a free-running 40-bit count of 1/1024-second ticks. An enable strobe from a 32 kHz reference drives the count. A divide-by-32 prescaler turns that strobe into the 1024 Hz tick. One control bit bypasses the prescaler so the count advances on every reference strobe. Software reaches the core through a byte-wide register bus. Elapsed seconds are the count shifted right by ten. A new time is written as seconds shifted left by ten.

Reading the count coherently takes several byte accesses. A read of the byte address just below the counter copies all forty bits into a snapshot. The five counter addresses that follow then return bytes of that frozen copy while the live count keeps running. Writes go the other way. The upper four counter bytes collect in staging registers. Writing the least significant byte loads all forty bits into the counter in a single cycle.

A 24-bit alarm value, in tick units, is compared with the low 24 bits of the count. When the alarm is enabled and the two first become equal, a sticky flag is set and drives the interrupt line. Software clears the flag by writing one to it, or by disabling the alarm.

Top module: `rtc_tick_core`

## Requirements
- R1: After reset, the control byte at 0xC0 reads 0x80, the alarm bytes and the counter snapshot bytes read 0x00, and irq is low.
- R2: Control byte 0xC0 is laid out as follows. Bit 7 is the power-on flag. Writing 0 to bit 7 clears it, writing 1 leaves it unchanged, and once cleared it stays 0 until reset. Bit 6 is the oscillator select and drives osc_src_sel. Bit 5 is the alarm enable. Bit 4 is the output-buffer enable and drives clkout_buf_en. Bit 3 is the prescaler bypass. Bits 2:1 are the load select and drive xtal_load_sel. Bits 6..1 read back as written. Bit 0 reads the alarm flag.
- R3: With bit 3 at 0, the counter advances by one on every 32nd reference strobe, counted from reset. With bit 3 at 1, it advances on every strobe.
- R4: A read of 0xC5 returns 0x00 and copies the live counter into the snapshot. Reads of 0xC6..0xCA return the snapshot bytes, most significant first, and they do not change as the live counter advances.
- R5: Writes to 0xC6..0xC9 stage the upper four counter bytes without changing the counter. A write to 0xCA loads the staged bytes and the written low byte into the counter in that cycle. This load takes precedence over a tick in the same cycle.
- R6: The 24-bit alarm value occupies 0xC1..0xC3, most significant byte first, and each byte reads back as written.
- R7: When the alarm is enabled, the flag is set in the cycle after the low 24 counter bits start to equal the alarm value. This includes the case where the alarm is enabled while the two are already equal. irq is high while the flag is set.
- R8: Writing 1 to bit 0 of 0xC0 clears the flag, and writing 0 to it has no effect. While the alarm is disabled, the flag is cleared and cannot be set. An equality that persists after a clear does not set the flag again.
- R9: Read data is registered. It appears on bus_rdata in the cycle after the read request and is 0x00 in every other cycle. Address 0xC4 and addresses outside 0xC0..0xCA read 0x00.
- R10: The counter wraps from all ones to zero on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle strobe from the 32 kHz reference |
| bus_sel | input | 1 | Register access request in this cycle |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high alarm interrupt |
| osc_src_sel | output | 1 | Oscillator source select (control bit 6) |
| clkout_buf_en | output | 1 | 32 kHz output buffer enable (control bit 4) |
| xtal_load_sel | output | 2 | Crystal load select (control bits 2:1) |

## Verification
The assertions check several rules on every cycle:
- the counter holds when there is neither a tick nor a load, and steps by exactly one on a tick;
- a load puts the written low byte into the counter;
- read data is zero when no read is requested;
- the power-on flag never returns once cleared;
- the interrupt only rises and only stays high while the alarm is enabled.

Some behaviours only the bench scenarios can show:
- the divide-by-32 phase of the prescaler;
- the coherence of a snapshot while the live count runs;
- the precedence of a load over a coincident tick;
- the wrap from all ones;
- the one-shot nature of the alarm after a write-one clear, and enabling the alarm onto a value that already matches.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W = 8;

  // Control byte bits 7..1; bit 0 of the byte is the alarm flag held in the alarm unit
  typedef struct packed {
    logic       por;
    logic       osc_sel;
    logic       alarm_en;
    logic       buf_en;
    logic       bypass;
    logic [1:0] load_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = ctrl_t'(7'h40);

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic bypass,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (ref_en && !bypass) begin
      if (phase_q == LAST) phase_q <= '0;
      else                 phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = ref_en & (bypass | (phase_q == LAST));

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [CNT_W/BYTE_W-2:0]      stage_we,
  input  logic                         commit,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic                         snap_take,
  input  logic [$clog2(CNT_W/BYTE_W)-1:0] rd_lane,
  output logic [CNT_W-1:0]             count_q,
  output logic [BYTE_W-1:0]            snap_byte
);

  localparam int NB = CNT_W / BYTE_W;
  localparam int HW = CNT_W - BYTE_W;

  logic [HW-1:0]    stage_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {stage_q, wdata};

  // Upper byte lanes collect here; lane 0 is the most significant byte
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      for (int i = 0; i < NB - 1; i++) begin
        if (stage_we[i]) stage_q[(NB-2-i)*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (commit) count_q <= load_val;
    else if (tick)   count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (snap_take) snap_q <= count_q;
  end

  logic [BYTE_W-1:0] snap_lanes [NB];
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign snap_lanes[g] = snap_q[CNT_W-1-g*BYTE_W -: BYTE_W];
  end

  assign snap_byte = snap_lanes[rd_lane];

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int ALM_W = 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ALM_W/BYTE_W-1:0]         lane_we,
  input  logic [BYTE_W-1:0]               wdata,
  input  logic [ALM_W-1:0]                cnt_lo,
  input  logic                            enable,
  input  logic                            flag_clr,
  input  logic [$clog2(ALM_W/BYTE_W)-1:0] rd_lane,
  output logic [BYTE_W-1:0]               rd_byte,
  output logic                            flag_q
);

  localparam int AB = ALM_W / BYTE_W;

  logic [ALM_W-1:0] alarm_q;
  logic             match;
  logic             match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
    end else begin
      for (int i = 0; i < AB; i++) begin
        if (lane_we[i]) alarm_q[(AB-1-i)*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  assign match = enable & (cnt_lo == alarm_q);

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match;
  end

  // Set on the first cycle of equality; set wins over a write-one clear
  always_ff @(posedge clk) begin
    if (rst)                  flag_q <= 1'b0;
    else if (!enable)         flag_q <= 1'b0;
    else if (match && !match_q) flag_q <= 1'b1;
    else if (flag_clr)        flag_q <= 1'b0;
  end

  logic [BYTE_W-1:0] alm_lanes [AB];
  for (genvar g = 0; g < AB; g++) begin : g_lane
    assign alm_lanes[g] = alarm_q[ALM_W-1-g*BYTE_W -: BYTE_W];
  end

  assign rd_byte = alm_lanes[rd_lane];

endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
  import rtc_pkg::*;
#(
  parameter int         CNT_W     = 40,
  parameter int         ALM_W     = 24,
  parameter int         PRE_DIV   = 32,
  parameter logic [7:0] BASE_ADDR = 8'hC0,
  parameter int         ALM_OFS   = 1,
  parameter int         CNT_OFS   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       osc_src_sel,
  output logic       clkout_buf_en,
  output logic [1:0] xtal_load_sel
);

  localparam int NB = CNT_W / BYTE_W;
  localparam int AB = ALM_W / BYTE_W;
  localparam int LW = $clog2(NB);
  localparam int AW = $clog2(AB);
  localparam logic [7:0] CTRL_A   = BASE_ADDR;
  localparam logic [7:0] ALM_A    = BASE_ADDR + 8'(ALM_OFS);
  localparam logic [7:0] ALM_LAST = ALM_A + 8'(AB - 1);
  localparam logic [7:0] CNT_A    = BASE_ADDR + 8'(CNT_OFS);
  localparam logic [7:0] CNT_LAST = CNT_A + 8'(NB - 1);
  localparam logic [7:0] SNAP_A   = CNT_A - 8'd1;

  // Decode
  logic wr_req, rd_req, in_cnt, in_alm, ctrl_hit;
  assign wr_req   = bus_sel & bus_wr;
  assign rd_req   = bus_sel & ~bus_wr;
  assign ctrl_hit = (bus_addr == CTRL_A);
  assign in_cnt   = (bus_addr >= CNT_A) && (bus_addr <= CNT_LAST);
  assign in_alm   = (bus_addr >= ALM_A) && (bus_addr <= ALM_LAST);

  logic [NB-1:0] cnt_we;
  logic [AB-1:0] alm_we;
  always_comb begin
    for (int i = 0; i < NB; i++) cnt_we[i] = wr_req && (bus_addr == CNT_A + 8'(i));
    for (int j = 0; j < AB; j++) alm_we[j] = wr_req && (bus_addr == ALM_A + 8'(j));
  end

  logic commit, snap_take, flag_clr;
  assign commit    = cnt_we[NB-1];
  assign snap_take = rd_req && (bus_addr == SNAP_A);
  assign flag_clr  = wr_req && ctrl_hit && bus_wdata[0];

  logic [LW-1:0] cnt_lane;
  logic [AW-1:0] alm_lane;
  assign cnt_lane = LW'(bus_addr - CNT_A);
  assign alm_lane = AW'(bus_addr - ALM_A);

  // Control register
  ctrl_t ctrl_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_req && ctrl_hit) begin
      ctrl_q.por      <= ctrl_q.por & bus_wdata[7];
      ctrl_q.osc_sel  <= bus_wdata[6];
      ctrl_q.alarm_en <= bus_wdata[5];
      ctrl_q.buf_en   <= bus_wdata[4];
      ctrl_q.bypass   <= bus_wdata[3];
      ctrl_q.load_sel <= bus_wdata[2:1];
    end
  end

  logic ctrl_aen, ctrl_por;
  assign ctrl_aen = ctrl_q.alarm_en;
  assign ctrl_por = ctrl_q.por;

  // Datapath units
  logic             tick;
  logic [CNT_W-1:0] count_live;
  logic [7:0]       snap_rd, alm_rd;
  logic             alarm_flag;

  rtc_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .ref_en (ref_en),
    .bypass (ctrl_q.bypass),
    .tick   (tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .stage_we  (cnt_we[NB-2:0]),
    .commit    (commit),
    .wdata     (bus_wdata),
    .snap_take (snap_take),
    .rd_lane   (cnt_lane),
    .count_q   (count_live),
    .snap_byte (snap_rd)
  );

  rtc_alarm #(.ALM_W(ALM_W)) u_alm (
    .clk      (clk),
    .rst      (rst),
    .lane_we  (alm_we),
    .wdata    (bus_wdata),
    .cnt_lo   (count_live[ALM_W-1:0]),
    .enable   (ctrl_aen),
    .flag_clr (flag_clr),
    .rd_lane  (alm_lane),
    .rd_byte  (alm_rd),
    .flag_q   (alarm_flag)
  );

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst || !rd_req) bus_rdata <= '0;
    else if (ctrl_hit)  bus_rdata <= {ctrl_q, alarm_flag};
    else if (in_alm)    bus_rdata <= alm_rd;
    else if (in_cnt)    bus_rdata <= snap_rd;
    else                bus_rdata <= '0;
  end

  assign irq           = alarm_flag;
  assign osc_src_sel   = ctrl_q.osc_sel;
  assign clkout_buf_en = ctrl_q.buf_en;
  assign xtal_load_sel = ctrl_q.load_sel;

endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk #(
  parameter int         CNT_W    = 40,
  parameter logic [7:0] CNT_LAST = 8'hCA
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic             ctrl_aen,
  input logic             ctrl_por,
  input logic             tick,
  input logic [CNT_W-1:0] count_live
);

  logic load_now;
  assign load_now = bus_sel && bus_wr && (bus_addr == CNT_LAST);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_now) |=> $stable(count_live));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_now) |=> (count_live == CNT_W'($past(count_live) + 1'b1)));

  assert_load_low_R5: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (count_live[7:0] == $past(bus_wdata)));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> (bus_rdata == 8'h00));

  assert_por_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_por |=> !ctrl_por);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl_aen |=> !irq);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ctrl_aen));

endmodule

bind rtc_tick_core rtc_tick_core_chk #(.CNT_W(CNT_W), .CNT_LAST(CNT_LAST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .ctrl_aen   (ctrl_aen),
  .ctrl_por   (ctrl_por),
  .tick       (tick),
  .count_live (count_live)
);

// File: tb/rtc_tick_core_tb.sv
module rtc_tick_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, osc_src_sel, clkout_buf_en;
  logic [1:0] xtal_load_sel;

  always #4 clk = ~clk;

  rtc_tick_core u_dut (
    .clk           (clk),
    .rst           (rst),
    .ref_en        (ref_en),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq           (irq),
    .osc_src_sel   (osc_src_sel),
    .clkout_buf_en (clkout_buf_en),
    .xtal_load_sel (xtal_load_sel)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  reported = 1'b0;

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    end
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  localparam longint unsigned MASK40 = 64'hFF_FFFF_FFFF;
  longint unsigned m_cnt, m_snap, m_old;
  int  m_stage [4];
  int  m_alarm, m_pre, m_load, m_rdata;
  bit  m_por, m_osc, m_aen, m_buf, m_byp, m_flag, m_mprev;
  bit  s_wr, s_rd, s_match, s_tick;
  int  s_a;
  logic [7:0] s_d;
  string m_tag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_snap = 0; m_alarm = 0; m_pre = 0; m_load = 0; m_rdata = 0;
      m_por = 1; m_osc = 0; m_aen = 0; m_buf = 0; m_byp = 0; m_flag = 0; m_mprev = 0;
      foreach (m_stage[i]) m_stage[i] = 0;
    end else begin
      s_wr = bus_sel && bus_wr;
      s_rd = bus_sel && !bus_wr;
      s_a  = int'(bus_addr);
      s_d  = bus_wdata;
      m_old = m_cnt;
      s_match = m_aen && ((m_old & 64'hFF_FFFF) == longint'(m_alarm));
      m_rdata = 0;
      m_tag = "R9";
      if (s_rd) begin
        if (s_a == 'hC0) begin
          m_rdata = m_por*128 + m_osc*64 + m_aen*32 + m_buf*16 + m_byp*8 + m_load*2 + m_flag;
          m_tag = "R2";
        end else if (s_a >= 'hC1 && s_a <= 'hC3) begin
          m_rdata = (m_alarm >> (8*(2-(s_a-'hC1)))) & 255;
          m_tag = "R6";
        end else if (s_a >= 'hC6 && s_a <= 'hCA) begin
          m_rdata = int'((m_snap >> (8*(4-(s_a-'hC6)))) & 255);
          m_tag = "R4";
        end
      end
      if (!m_aen) m_flag = 0;
      else if (s_match && !m_mprev) m_flag = 1;
      else if (s_wr && s_a == 'hC0 && s_d[0]) m_flag = 0;
      m_mprev = s_match;
      s_tick = ref_en && (m_byp || m_pre == 31);
      if (ref_en && !m_byp) m_pre = (m_pre + 1) % 32;
      if (s_wr && s_a == 'hCA)
        m_cnt = (longint'(m_stage[0]) << 32) | (longint'(m_stage[1]) << 24) |
                (longint'(m_stage[2]) << 16) | (longint'(m_stage[3]) << 8) | longint'(s_d);
      else if (s_tick)
        m_cnt = (m_old + 1) & MASK40;
      if (s_rd && s_a == 'hC5) m_snap = m_old;
      if (s_wr && s_a >= 'hC6 && s_a <= 'hC9) m_stage[s_a-'hC6] = int'(s_d);
      if (s_wr && s_a >= 'hC1 && s_a <= 'hC3)
        m_alarm = (m_alarm & ~(255 << (8*(2-(s_a-'hC1))))) | (int'(s_d) << (8*(2-(s_a-'hC1))));
      if (s_wr && s_a == 'hC0) begin
        m_por = m_por & s_d[7]; m_osc = s_d[6]; m_aen = s_d[5];
        m_buf = s_d[4]; m_byp = s_d[3]; m_load = int'(s_d[2:1]);
      end
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(m_tag, bus_rdata, m_rdata);
      check("R7", irq, m_flag);
      check("R2", osc_src_sel, m_osc);
      check("R2", clkout_buf_en, m_buf);
      check("R2", xtal_load_sel, m_load);
    end
  end

  // ---------------- bus helpers (called at a falling edge) ----------------
  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic read_snap(output longint unsigned v);
    logic [7:0] b;
    bread(8'hC5, b);
    v = 0;
    for (int i = 0; i < 5; i++) begin
      bread(8'hC6 + 8'(i), b);
      v = (v << 8) | longint'(b);
    end
  endtask

  task automatic load_cnt(input longint unsigned v);
    for (int i = 0; i < 5; i++) bwrite(8'hC6 + 8'(i), 8'((v >> (8*(4-i))) & 255));
  endtask

  task automatic pulses(input int n);
    ref_en = 1;
    repeat (n) @(negedge clk);
    ref_en = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  // ---------------- directed scenarios ----------------
  logic [7:0] rb;
  longint unsigned sv;

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    bread(8'hC0, rb);  check("R1 ctrl", rb, 8'h80);
    bread(8'hC1, rb);  check("R1 alarm", rb, 8'h00);
    read_snap(sv);     check("R1 counter", sv, 0);
    check("R1 irq", irq, 0);

    // R2 control bits, power-on flag semantics
    bwrite(8'hC0, 8'hDE); bread(8'hC0, rb); check("R2 keep por", rb, 8'hDE);
    check("R2 osc", osc_src_sel, 1); check("R2 buf", clkout_buf_en, 1); check("R2 load", xtal_load_sel, 2'd3);
    bwrite(8'hC0, 8'h1E); bread(8'hC0, rb); check("R2 clear por", rb, 8'h1E);
    bwrite(8'hC0, 8'h80); bread(8'hC0, rb); check("R2 por stays clear", rb, 8'h00);

    // R3 prescaled and bypassed rates
    pulses(64); read_snap(sv); check("R3 divided", sv, 2);
    pulses(31); read_snap(sv); check("R3 divided phase", sv, 2);
    pulses(1);  read_snap(sv); check("R3 divided 32nd", sv, 3);
    bwrite(8'hC0, 8'h08);
    pulses(10); read_snap(sv); check("R3 bypass", sv, 13);

    // R4 snapshot coherence
    bread(8'hC5, rb); check("R4 trigger reads zero", rb, 8'h00);
    pulses(300);
    sv = 0;
    for (int i = 0; i < 5; i++) begin
      bread(8'hC6 + 8'(i), rb); sv = (sv << 8) | longint'(rb);
    end
    check("R4 frozen", sv, 13);
    read_snap(sv); check("R4 refreshed", sv, 313);

    // R5 staging and single-cycle load, load beats tick
    bwrite(8'hC6, 8'hA1); bwrite(8'hC7, 8'hB2); bwrite(8'hC8, 8'hC3); bwrite(8'hC9, 8'hD4);
    read_snap(sv); check("R5 staged only", sv, 313);
    ref_en = 1; bwrite(8'hCA, 8'hE5); ref_en = 0;
    read_snap(sv); check("R5 loaded", sv, 64'hA1_B2C3_D4E5);

    // R10 wrap
    load_cnt(64'hFF_FFFF_FFFF); pulses(1);
    read_snap(sv); check("R10 wrap", sv, 0);

    // R6 alarm bytes
    bwrite(8'hC1, 8'h12); bwrite(8'hC2, 8'h34); bwrite(8'hC3, 8'h56);
    bread(8'hC1, rb); check("R6 hi", rb, 8'h12);
    bread(8'hC2, rb); check("R6 mid", rb, 8'h34);
    bread(8'hC3, rb); check("R6 lo", rb, 8'h56);

    // R7 alarm match on low 24 bits (upper bits differ)
    load_cnt(64'h77_0012_3450); bwrite(8'hC0, 8'h28);
    pulses(5); repeat (3) @(negedge clk); check("R7 before match", irq, 0);
    pulses(1); repeat (3) @(negedge clk); check("R7 at match", irq, 1);
    bread(8'hC0, rb); check("R7 flag bit", rb, 8'h29);

    // R8 clearing rules
    bwrite(8'hC0, 8'h28); @(negedge clk); check("R8 write zero keeps", irq, 1);
    bwrite(8'hC0, 8'h29); repeat (3) @(negedge clk); check("R8 w1c no refire", irq, 0);
    bwrite(8'hC0, 8'h08); load_cnt(64'h12_3455); bwrite(8'hC0, 8'h28);
    pulses(1); repeat (3) @(negedge clk); check("R7 second match", irq, 1);
    bwrite(8'hC0, 8'h08); repeat (3) @(negedge clk); check("R8 disable clears", irq, 0);
    load_cnt(64'h12_3455); pulses(1); repeat (3) @(negedge clk); check("R8 disabled no set", irq, 0);
    bwrite(8'hC0, 8'h28); repeat (3) @(negedge clk); check("R7 enable onto match", irq, 1);
    bwrite(8'hC0, 8'h08); repeat (2) @(negedge clk);

    // R9 unmapped reads and idle data
    bread(8'hC4, rb); check("R9 gap", rb, 8'h00);
    bread(8'h10, rb); check("R9 outside", rb, 8'h00);
    bread(8'hCB, rb); check("R9 past end", rb, 8'h00);
    @(negedge clk); check("R9 idle", bus_rdata, 8'h00);

    repeat (4) @(negedge clk);
    report();
  end

endmodule